// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This block sits between a 32-bit processor core and a word-addressed 32-bit data memory. It handles the byte and half-word handling that the memory itself does not do. On the store side, it takes the register value, the access size and the two low address bits. It produces write data with the relevant low part of the register copied into every lane, plus a byte-enable mask, so that the mask alone decides which bytes of the memory word change.

On the load side, it takes the word read from memory, picks the byte or half-word lane named by the low address bits (little-endian), and widens it to 32 bits. The widening fills with zeros or with copies of the lane's top bit, chosen by a signedness input. A word load passes through unchanged.

The store path, the load path and a misalignment flag are all computed from the same size and address inputs in every cycle. All outputs are registered, so they follow the inputs by one clock.

Top module: `lane_unit`

## Requirements
- R1: While `rst_n` is low, `wr_data`, `wr_be`, `ld_result` and `misaligned` are all zero.
- R2: Each output reflects the inputs sampled at the previous rising edge of `clk`. An input change is not visible at the outputs before that edge.
- R3: For a byte access (`acc_size` = 2'b00), `wr_data` holds `st_reg[7:0]` in all four byte lanes, and `wr_be` has only bit `addr_lo` set.
- R4: For a half-word access (`acc_size` = 2'b01), `wr_data` holds `st_reg[15:0]` in both halves. `wr_be` is 4'b0011 when `addr_lo[1]` is 0 and 4'b1100 when it is 1; `addr_lo[0]` does not move the lanes.
- R5: For a word access (`acc_size` = 2'b10 or 2'b11), `wr_data` equals `st_reg` and `wr_be` is 4'b1111.
- R6: An unsigned byte load (`load_signed` = 0) returns bits 8*`addr_lo`+7 down to 8*`addr_lo` of `rd_word` in bits 7:0, with bits 31:8 zero.
- R7: A signed byte load (`load_signed` = 1) returns the same byte in bits 7:0, with bits 31:8 all equal to that byte's bit 7.
- R8: An unsigned half-word load returns `rd_word[15:0]` when `addr_lo[1]` is 0 and `rd_word[31:16]` when it is 1, in bits 15:0, with bits 31:16 zero.
- R9: A signed half-word load returns the same half in bits 15:0, with bits 31:16 all equal to its bit 15.
- R10: A word load returns `rd_word` unchanged, whatever the values of `load_signed` and `addr_lo`.
- R11: `misaligned` is 1 for a half-word access with `addr_lo[0]` = 1, and for a word access with `addr_lo` nonzero. It is always 0 for byte accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_size | input | 2 | Access size: 00 byte, 01 half-word, 1x word |
| load_signed | input | 1 | 1 selects sign extension for sub-word loads |
| addr_lo | input | 2 | Low two bits of the byte address |
| st_reg | input | 32 | Register value to be stored |
| rd_word | input | 32 | Word read from data memory |
| wr_data | output | 32 | Lane-replicated store data |
| wr_be | output | 4 | Byte enables for the store |
| ld_result | output | 32 | Extended load result |
| misaligned | output | 1 | Access is not aligned to its size |

## Verification
The block holds no state beyond one output register, so any internal fault appears at the ports exactly one clock after the stimulus that exposes it. A wrong lane index shows up as the wrong byte in `ld_result`, or as an enable bit in the wrong position. A wrong extension shows up as the wrong fill above bit 7 or bit 15. The bench checks every output in the cycle after each stimulus. It covers all size, signedness and address combinations, with data whose top lane bits are both set and clear, so each of these faults is caught on the first access that depends on it.

// File: rtl/lane_unit_pkg.sv
package lane_unit_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } lane_size_e;

    function automatic logic is_word(input lane_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_WORD2);
    endfunction

endpackage

// File: rtl/store_lane_pack.sv
module store_lane_pack
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(LANES)
) (
    input  lane_size_e          size,
    input  logic [AW-1:0]       addr,
    input  logic [DATA_W-1:0]   src,
    output logic [DATA_W-1:0]   wdata,
    output logic [LANES-1:0]    be
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    wdata[8*i +: 8] = src[7:0];
                    be[i]           = (addr == AW'(i));
                end
                SZ_HALF: begin
                    wdata[8*i +: 8] = src[8*(i%2) +: 8];
                    be[i]           = (addr[AW-1:1] == (AW-1)'(i/2));
                end
                default: begin
                    wdata[8*i +: 8] = src[8*i +: 8];
                    be[i]           = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/load_lane_extract.sv
module load_lane_extract
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(LANES)
) (
    input  lane_size_e          size,
    input  logic                sign_ext,
    input  logic [AW-1:0]       addr,
    input  logic [DATA_W-1:0]   rword,
    output logic [DATA_W-1:0]   result
);

    logic [7:0]  lane_b [LANES];
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;
    logic        fill;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lane_b[i] = rword[8*i +: 8];
    end

    always_comb begin
        byte_sel = lane_b[addr];
        half_sel = {lane_b[{addr[AW-1:1], 1'b1}], lane_b[{addr[AW-1:1], 1'b0}]};
        result   = rword;
        unique case (size)
            SZ_BYTE: begin
                fill   = sign_ext & byte_sel[7];
                result = {{(DATA_W-8){fill}}, byte_sel};
            end
            SZ_HALF: begin
                fill   = sign_ext & half_sel[15];
                result = {{(DATA_W-16){fill}}, half_sel};
            end
            default: begin
                fill   = 1'b0;
                result = rword;
            end
        endcase
    end

endmodule

// File: rtl/misalign_detect.sv
module misalign_detect
    import lane_unit_pkg::*;
#(
    parameter int AW = 2
) (
    input  lane_size_e    size,
    input  logic [AW-1:0] addr,
    output logic          flag
);

    always_comb begin
        unique case (size)
            SZ_BYTE: flag = 1'b0;
            SZ_HALF: flag = addr[0];
            default: flag = |addr;
        endcase
    end

endmodule

// File: rtl/lane_unit.sv
module lane_unit
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int AW    = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_size,
    input  logic              load_signed,
    input  logic [AW-1:0]     addr_lo,
    input  logic [DATA_W-1:0] st_reg,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] ld_result,
    output logic              misaligned
);

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] ldata;
        logic              mis;
    } lane_regs_t;

    lane_regs_t        regs_d, regs_q;
    lane_size_e        size_w;
    logic [DATA_W-1:0] pack_wdata_w;
    logic [LANES-1:0]  pack_be_w;
    logic [DATA_W-1:0] ext_w;
    logic              mis_w;

    assign size_w = lane_size_e'(acc_size);

    store_lane_pack #(.DATA_W(DATA_W)) u_store (
        .size  (size_w),
        .addr  (addr_lo),
        .src   (st_reg),
        .wdata (pack_wdata_w),
        .be    (pack_be_w)
    );

    load_lane_extract #(.DATA_W(DATA_W)) u_load (
        .size     (size_w),
        .sign_ext (load_signed),
        .addr     (addr_lo),
        .rword    (rd_word),
        .result   (ext_w)
    );

    misalign_detect #(.AW(AW)) u_mis (
        .size (size_w),
        .addr (addr_lo),
        .flag (mis_w)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.wdata = pack_wdata_w;
        regs_d.be    = pack_be_w;
        regs_d.ldata = ext_w;
        regs_d.mis   = mis_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign wr_data    = regs_q.wdata;
    assign wr_be      = regs_q.be;
    assign ld_result  = regs_q.ldata;
    assign misaligned = regs_q.mis;

    AST_BYTE_BE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00) |=> ($countones(wr_be) == 1)); // R3
    AST_HALF_BE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01) |=> (wr_be == 4'b0011 || wr_be == 4'b1100)); // R4
    AST_WORD_BE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_size[1] |=> (wr_be == 4'b1111)); // R5
    AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00 && !load_signed) |=> (ld_result[DATA_W-1:8] == '0)); // R6
    AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00 && load_signed) |=> (ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}})); // R7
    AST_HALF_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01 && !load_signed) |=> (ld_result[DATA_W-1:16] == '0)); // R8
    AST_HALF_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b01 && load_signed) |=> (ld_result[DATA_W-1:16] == {(DATA_W-16){ld_result[15]}})); // R9
    AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_size[1] |=> (ld_result == $past(rd_word))); // R10
    AST_BYTE_NEVER_MIS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'b00) |=> !misaligned); // R11

endmodule

// File: tb/sim_lane_unit.sv
`timescale 1ns/1ps
module sim_lane_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  acc_size;
    logic        load_signed;
    logic [1:0]  addr_lo;
    logic [31:0] st_reg;
    logic [31:0] rd_word;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [31:0] ld_result;
    logic        misaligned;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    lane_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .load_signed(load_signed),
        .addr_lo(addr_lo), .st_reg(st_reg), .rd_word(rd_word),
        .wr_data(wr_data), .wr_be(wr_be), .ld_result(ld_result), .misaligned(misaligned)
    );

    function automatic logic [31:0] ref_wdata(input logic [1:0] sz, input logic [31:0] r);
        case (sz)
            2'b00:   return {4{r[7:0]}};
            2'b01:   return {2{r[15:0]}};
            default: return r;
        endcase
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00:   return 4'b0001 << a;
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic sg,
                                            input logic [1:0] a, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        case (a)
            2'd0: b = w[7:0];
            2'd1: b = w[15:8];
            2'd2: b = w[23:16];
            default: b = w[31:24];
        endcase
        h = a[1] ? w[31:16] : w[15:0];
        case (sz)
            2'b00:   return sg ? {{24{b[7]}}, b} : {24'h0, b};
            2'b01:   return sg ? {{16{h[15]}}, h} : {16'h0, h};
            default: return w;
        endcase
    endfunction

    function automatic logic ref_mis(input logic [1:0] sz, input logic [1:0] a);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return a[0];
        return a != 2'b00;
    endfunction

    function automatic string load_tag(input logic [1:0] sz, input logic sg);
        if (sz == 2'b00) return sg ? "R7" : "R6";
        if (sz == 2'b01) return sg ? "R9" : "R8";
        return "R10";
    endfunction

    function automatic string store_tag(input logic [1:0] sz);
        if (sz == 2'b00) return "R3";
        if (sz == 2'b01) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] sz, input logic sg, input logic [1:0] a,
                          input logic [31:0] sr, input logic [31:0] rw);
        @(negedge clk);
        acc_size = sz; load_signed = sg; addr_lo = a; st_reg = sr; rd_word = rw;
        @(negedge clk);
        chk(store_tag(sz), wr_data, ref_wdata(sz, sr));
        chk(store_tag(sz), {28'h0, wr_be}, {28'h0, ref_be(sz, a)});
        chk(load_tag(sz, sg), ld_result, ref_load(sz, sg, a, rw));
        chk("R11", {31'h0, misaligned}, {31'h0, ref_mis(sz, a)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        acc_size = 2'b10; load_signed = 1'b1; addr_lo = 2'd3;
        st_reg = 32'hdead_beef; rd_word = 32'hcafe_f00d;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset despite active inputs
        chk("R1", wr_data, 32'h0);
        chk("R1", {28'h0, wr_be}, 32'h0);
        chk("R1", ld_result, 32'h0);
        chk("R1", {31'h0, misaligned}, 32'h0);
        rst_n = 1'b1;

        // R2: one-cycle latency
        access(2'b10, 1'b0, 2'd0, 32'h1111_1111, 32'h2222_2222);
        @(negedge clk);
        acc_size = 2'b00; load_signed = 1'b0; addr_lo = 2'd2;
        st_reg = 32'h0000_00ab; rd_word = 32'h00cd_0000;
        #1;
        chk("R2", wr_data, 32'h1111_1111);
        chk("R2", ld_result, 32'h2222_2222);
        @(negedge clk);
        chk("R2", wr_data, 32'habab_abab);
        chk("R2", ld_result, 32'h0000_00cd);

        // directed corner cases
        for (int a = 0; a < 4; a++) begin
            access(2'b00, 1'b1, 2'(a), 32'h1234_5680, 32'h8080_8080); // R3 R7 sign lanes
            access(2'b00, 1'b0, 2'(a), 32'hffff_ff7f, 32'h8080_8080); // R6
            access(2'b01, 1'b1, 2'(a), 32'hbeef_8001, 32'h8001_7ffe); // R4 R9 R11
            access(2'b01, 1'b0, 2'(a), 32'h0000_ffff, 32'h8001_8001); // R8
            access(2'b10, 1'b1, 2'(a), 32'h8000_0001, 32'hffff_0080); // R5 R10 R11
            access(2'b11, 1'b0, 2'(a), 32'h0123_4567, 32'h89ab_cdef); // R5 R10
        end

        // constrained random
        for (int n = 0; n < 1500; n++) begin
            access(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   2'($urandom_range(0, 3)), $urandom, $urandom);
        end

        finish_run();
    end

endmodule